// File: doc/BRIEF.md
# Supply Fault Latch Register Bank

This block watches twelve digital status signals. Seven come from supply fault detectors, four are general-purpose inputs and one is a watchdog timeout flag. Each clock it compares every signal with its value in the previous cycle. When an unmasked signal changes, in either direction, the block raises a sticky fault flag. On the same edge it freezes a snapshot into two fault registers. The first fault register holds the flag and the levels of the seven detectors at that moment. The second holds one change marker for each general-purpose input and one for the watchdog.

The snapshot holds until software issues a read strobe to the second fault register. Until then, later changes do not disturb it. A detector that falls back into tolerance is therefore recorded as 0 while the flag reads 1, which can look like a contradiction when it is read much later. If a change arrives in the same cycle as the clearing read, the block does not drop it. It latches the change one cycle later.

Software reaches the block through a plain register port with address, read strobe, write strobe, write data and combinational read data. Two writable mask registers select which signals are ignored. Four read-only registers show the live comparator, detector and input levels.

Top module: `sfl_top`

## Requirements
- R1: After the synchronous reset, both fault registers and both mask registers read 0x00 and `fault_any` is 0.
- R2: A change of level in either direction on any unmasked monitored signal sets `fault_any` and bit 7 of fault register 1 (0xDC) at the next clock edge.
- R3: When latching, bits 6:0 of 0xDC take `det_lvl[6:0]` bit for bit, with bits set in mask 1 forced to 0.
- R4: In fault register 2 (0xDD), bit 4 marks a watchdog change and bits 3:0 mark changes on `gpi_lvl[3:0]`, bit for bit. Bits 7:5 always read 0.
- R5: While the flag is set, further input changes leave both fault registers unchanged.
- R6: A cycle with `reg_rd`=1 and address 0xDD returns the pre-clear contents and clears both fault registers and the flag at that edge. Reading other addresses, or presenting 0xDD without the strobe, clears nothing.
- R7: A change seen in the same cycle as a clearing read is latched at the following edge.
- R8: Mask 1 sits at 0xE0, bits 6:0, mapped like 0xDC. Mask 2 sits at 0xE1, bits 4:0, mapped like 0xDD. Unused bits read 0, so bit 7 of mask 1 is never writable.
- R9: A change on a masked signal neither sets the flag nor triggers latching, and that signal's fault bit stays 0.
- R10: Live status: 0xD8 reads `uv_lvl`, 0xD9 reads `ov_lvl`, 0xDA reads `det_lvl`, and 0xDB reads {3'b0, `wdog_lvl`, `gpi_lvl`}.
- R11: Unmapped addresses read 0x00, and writes to addresses other than 0xE0 and 0xE1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_lvl | input | 7 | Supply detector outputs, 1 = out of tolerance |
| uv_lvl | input | 7 | Undervoltage comparator levels |
| ov_lvl | input | 7 | Overvoltage comparator levels |
| gpi_lvl | input | 4 | General-purpose input levels |
| wdog_lvl | input | 1 | Watchdog timeout level |
| reg_addr | input | 8 | Register address |
| reg_rd | input | 1 | Read strobe, clears the faults when addressed to 0xDD |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| fault_any | output | 1 | Sticky fault flag |

## Verification
A stale previous-level register produces a missing or spurious fault flag on the edge right after a stimulus, and both fault registers show it in the next read. A snapshot that is not frozen shows up as changed detector bits after a second toggle. A lost pending event appears as empty fault registers one cycle after a clearing read that coincided with a change. A mask that is not applied shows up as a set flag on the very next edge.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DET_N  = 7;
    localparam int GPI_N  = 4;
    localparam int GW_N   = GPI_N + 1;
    localparam int MON_N  = DET_N + GW_N;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_UV    = 8'hD8;
    localparam logic [ADDR_W-1:0] ADR_OV    = 8'hD9;
    localparam logic [ADDR_W-1:0] ADR_DET   = 8'hDA;
    localparam logic [ADDR_W-1:0] ADR_GW    = 8'hDB;
    localparam logic [ADDR_W-1:0] ADR_FLT1  = 8'hDC;
    localparam logic [ADDR_W-1:0] ADR_FLT2  = 8'hDD;
    localparam logic [ADDR_W-1:0] ADR_MSK1  = 8'hE0;
    localparam logic [ADDR_W-1:0] ADR_MSK2  = 8'hE1;

    // Monitored signal vector: detectors in the low bits, then GPIs, then watchdog.
    typedef struct packed {
        logic             wd;
        logic [GPI_N-1:0] gpi;
        logic [DET_N-1:0] det;
    } mon_t;

    function automatic logic [GW_N-1:0] gw_part(input mon_t v);
        return {v.wd, v.gpi};
    endfunction
endpackage

// File: rtl/sfl_change_det.sv
module sfl_change_det
    import sfl_pkg::*;
(
    input  logic             clk,
    input  mon_t             cur,
    input  mon_t             mask,
    output logic [MON_N-1:0] chg
);
    timeunit 1ns;
    timeprecision 100ps;

    mon_t prev_q;

    // Tracks the input also during reset so that release produces no event.
    always_ff @(posedge clk) begin
        prev_q <= cur;
    end

    genvar gi;
    generate
        for (gi = 0; gi < MON_N; gi++) begin : g_bit
            assign chg[gi] = (cur[gi] ^ prev_q[gi]) & ~mask[gi];
        end
    endgenerate
endmodule

// File: rtl/sfl_mask_regs.sv
module sfl_mask_regs
    import sfl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output mon_t              mask
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [DET_N-1:0] det_m_q;
    logic [GW_N-1:0]  gw_m_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            det_m_q <= '0;
            gw_m_q  <= '0;
        end else if (wr) begin
            if (addr == ADR_MSK1) det_m_q <= wdata[DET_N-1:0];
            if (addr == ADR_MSK2) gw_m_q  <= wdata[GW_N-1:0];
        end
    end

    always_comb begin
        mask     = '0;
        mask.det = det_m_q;
        mask.gpi = gw_m_q[GPI_N-1:0];
        mask.wd  = gw_m_q[GW_N-1];
    end
endmodule

// File: rtl/sfl_latch.sv
module sfl_latch
    import sfl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [MON_N-1:0] chg,
    input  logic [DET_N-1:0] det_now,
    input  logic [DET_N-1:0] det_mask,
    output logic             any_q,
    output logic [DET_N-1:0] snap_det_q,
    output logic [GW_N-1:0]  snap_gw_q,
    output logic [MON_N-1:0] pend_q
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [MON_N-1:0] eff;
    assign eff = chg | pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            any_q      <= 1'b0;
            snap_det_q <= '0;
            snap_gw_q  <= '0;
            pend_q     <= '0;
        end else if (clr) begin
            any_q      <= 1'b0;
            snap_det_q <= '0;
            snap_gw_q  <= '0;
            pend_q     <= eff;
        end else begin
            pend_q <= '0;
            if (!any_q && (|eff)) begin
                any_q      <= 1'b1;
                snap_det_q <= det_now & ~det_mask;
                snap_gw_q  <= eff[MON_N-1:DET_N];
            end
        end
    end
endmodule

// File: rtl/sfl_read_mux.sv
module sfl_read_mux
    import sfl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DET_N-1:0]  uv,
    input  logic [DET_N-1:0]  ov,
    input  mon_t              live,
    input  logic              any_q,
    input  logic [DET_N-1:0]  snap_det,
    input  logic [GW_N-1:0]   snap_gw,
    input  mon_t              mask,
    output logic [DATA_W-1:0] rdata
);
    timeunit 1ns;
    timeprecision 100ps;

    always_comb begin
        unique case (addr)
            ADR_UV:   rdata = DATA_W'(uv);
            ADR_OV:   rdata = DATA_W'(ov);
            ADR_DET:  rdata = DATA_W'(live.det);
            ADR_GW:   rdata = DATA_W'(gw_part(live));
            ADR_FLT1: rdata = DATA_W'({any_q, snap_det});
            ADR_FLT2: rdata = DATA_W'(snap_gw);
            ADR_MSK1: rdata = DATA_W'(mask.det);
            ADR_MSK2: rdata = DATA_W'(gw_part(mask));
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/sfl_top.sv
module sfl_top
    import sfl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DET_N-1:0]  det_lvl,
    input  logic [DET_N-1:0]  uv_lvl,
    input  logic [DET_N-1:0]  ov_lvl,
    input  logic [GPI_N-1:0]  gpi_lvl,
    input  logic              wdog_lvl,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              fault_any
);
    timeunit 1ns;
    timeprecision 100ps;

    mon_t             live;
    mon_t             mask;
    logic [MON_N-1:0] chg;
    logic [MON_N-1:0] pend_q;
    logic             any_q;
    logic [DET_N-1:0] snap_det_q;
    logic [GW_N-1:0]  snap_gw_q;
    logic             clr_req;

    always_comb begin
        live.det = det_lvl;
        live.gpi = gpi_lvl;
        live.wd  = wdog_lvl;
    end

    assign clr_req = reg_rd && (reg_addr == ADR_FLT2);

    sfl_change_det u_chg (
        .clk  (clk),
        .cur  (live),
        .mask (mask),
        .chg  (chg)
    );

    sfl_mask_regs u_msk (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .mask  (mask)
    );

    sfl_latch u_lat (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_req),
        .chg        (chg),
        .det_now    (det_lvl),
        .det_mask   (mask.det),
        .any_q      (any_q),
        .snap_det_q (snap_det_q),
        .snap_gw_q  (snap_gw_q),
        .pend_q     (pend_q)
    );

    sfl_read_mux u_rd (
        .addr     (reg_addr),
        .uv       (uv_lvl),
        .ov       (ov_lvl),
        .live     (live),
        .any_q    (any_q),
        .snap_det (snap_det_q),
        .snap_gw  (snap_gw_q),
        .mask     (mask),
        .rdata    (reg_rdata)
    );

    assign fault_any = any_q;
endmodule

// File: rtl/sfl_chk.sv
module sfl_chk
    import sfl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              any_q,
    input logic              clr,
    input logic [DET_N-1:0]  snap_det,
    input logic [GW_N-1:0]   snap_gw,
    input logic [MON_N-1:0]  chg,
    input logic [MON_N-1:0]  pend,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata
);
    timeunit 1ns;
    timeprecision 100ps;

    // R5
    any_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (any_q && !clr) |=> any_q);

    // R6
    clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!any_q && snap_det == '0 && snap_gw == '0));

    // R5
    snap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (any_q && !clr) |=> ($stable(snap_det) && $stable(snap_gw)));

    // R9
    quiet_no_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (!any_q && !clr && pend == '0 && chg == '0) |=> !any_q);

    // R4
    f2_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADR_FLT2) |-> (reg_rdata[DATA_W-1:GW_N] == '0));

    // R8
    mask_rsv_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADR_MSK1) |-> !reg_rdata[DATA_W-1]);
endmodule

bind sfl_top sfl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .any_q     (any_q),
    .clr       (clr_req),
    .snap_det  (snap_det_q),
    .snap_gw   (snap_gw_q),
    .chg       (chg),
    .pend      (pend_q),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/sfl_top_tb_top.sv
module sfl_top_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] det_lvl = '0;
    logic [6:0] uv_lvl = '0;
    logic [6:0] ov_lvl = '0;
    logic [3:0] gpi_lvl = '0;
    logic       wdog_lvl = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       fault_any;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    sfl_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .det_lvl   (det_lvl),
        .uv_lvl    (uv_lvl),
        .ov_lvl    (ov_lvl),
        .gpi_lvl   (gpi_lvl),
        .wdog_lvl  (wdog_lvl),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fault_any (fault_any)
    );

    typedef struct packed {
        logic [6:0] det;
        logic [3:0] gpi;
        logic       wd;
        logic [7:0] e1;
        logic [7:0] e2;
        logic       clr;
    } vec_t;

    // Masks zero. Each row: new inputs, expected 0xDC/0xDD after one edge, clear afterwards.
    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{7'h00, 4'h0, 1'b0, 8'h00, 8'h00, 1'b0},  // R2 no change, no event
        '{7'h08, 4'h0, 1'b0, 8'h88, 8'h00, 1'b1},  // R2 R3 rising detector
        '{7'h00, 4'h0, 1'b0, 8'h80, 8'h00, 1'b1},  // R3 back in tolerance latches 0
        '{7'h08, 4'h0, 1'b0, 8'h88, 8'h00, 1'b0},  // R2 rising again, kept
        '{7'h00, 4'h0, 1'b0, 8'h88, 8'h00, 1'b1},  // R5 frozen snapshot
        '{7'h00, 4'h4, 1'b0, 8'h80, 8'h04, 1'b1},  // R4 gpi bit 2
        '{7'h00, 4'h4, 1'b1, 8'h80, 8'h10, 1'b1},  // R4 watchdog bit 4
        '{7'h7F, 4'h4, 1'b1, 8'hFF, 8'h00, 1'b1},  // R3 all detectors
        '{7'h7F, 4'hF, 1'b1, 8'hFF, 8'h0B, 1'b1},  // R4 three gpi changes
        '{7'h7F, 4'hF, 1'b1, 8'h00, 8'h00, 1'b0}   // R2 steady after clear
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic edge_sample();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_faults();
        @(negedge clk);
        reg_addr = 8'hDD;
        reg_rd   = 1'b1;
        edge_sample();
        reg_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        edge_sample();
        reg_wr = 1'b0;
    endtask

    task automatic set_in(input logic [6:0] d, input logic [3:0] g, input logic w);
        @(negedge clk);
        det_lvl  = d;
        gpi_lvl  = g;
        wdog_lvl = w;
        edge_sample();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        edge_sample();

        // R1 reset state
        peek(8'hDC, d); check("R1 fault1", d, 8'h00);
        peek(8'hDD, d); check("R1 fault2", d, 8'h00);
        peek(8'hE0, d); check("R1 mask1", d, 8'h00);
        peek(8'hE1, d); check("R1 mask2", d, 8'h00);
        check("R1 flag", {7'b0, fault_any}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            set_in(VEC[i].det, VEC[i].gpi, VEC[i].wd);
            peek(8'hDC, d); check($sformatf("R2/R3/R5 vec%0d fault1", i), d, VEC[i].e1);
            peek(8'hDD, d); check($sformatf("R4 vec%0d fault2", i), d, VEC[i].e2);
            if (i == 1) check("R2 pin", {7'b0, fault_any}, 8'h01);
            if (VEC[i].clr) clear_faults();
        end

        // R8 mask write and readback, unused bits read 0
        wr_reg(8'hE0, 8'hFF);
        peek(8'hE0, d); check("R8 mask1 readback", d, 8'h7F);
        wr_reg(8'hE1, 8'hFF);
        peek(8'hE1, d); check("R8 mask2 readback", d, 8'h1F);
        // R11 write elsewhere ignored
        wr_reg(8'hD8, 8'hFF);
        peek(8'hD8, d); check("R11 write to status", d, 8'h00);
        wr_reg(8'hDC, 8'hFF);
        peek(8'hDC, d); check("R11 write to fault1", d, 8'h00);

        // R9 all masked: every signal changes, nothing latches
        set_in(7'h00, 4'h0, 1'b0);
        peek(8'hDC, d); check("R9 all masked fault1", d, 8'h00);
        peek(8'hDD, d); check("R9 all masked fault2", d, 8'h00);
        check("R9 all masked flag", {7'b0, fault_any}, 8'h00);

        // R9 partial masks
        wr_reg(8'hE0, 8'h08);
        wr_reg(8'hE1, 8'h01);
        set_in(7'h09, 4'h0, 1'b0);
        peek(8'hDC, d); check("R9 R3 masked det bit", d, 8'h81);
        clear_faults();
        set_in(7'h09, 4'h1, 1'b0);
        peek(8'hDD, d); check("R9 masked gpi0 fault2", d, 8'h00);
        check("R9 masked gpi0 flag", {7'b0, fault_any}, 8'h00);
        set_in(7'h09, 4'h3, 1'b0);
        peek(8'hDD, d); check("R9 gpi1 unmasked", d, 8'h02);
        peek(8'hDC, d); check("R9 R3 snapshot", d, 8'h81);
        clear_faults();
        wr_reg(8'hE0, 8'h00);
        wr_reg(8'hE1, 8'h00);

        // R6 R7 change coinciding with clearing read
        set_in(7'h09, 4'h3, 1'b1);
        peek(8'hDD, d); check("R4 wd latched", d, 8'h10);
        @(negedge clk);
        gpi_lvl  = 4'h7;
        reg_addr = 8'hDD;
        reg_rd   = 1'b1;
        #0.2;
        check("R6 pre-clear data", reg_rdata, 8'h10);
        edge_sample();
        reg_rd = 1'b0;
        peek(8'hDC, d); check("R6 cleared fault1", d, 8'h00);
        peek(8'hDD, d); check("R6 cleared fault2", d, 8'h00);
        edge_sample();
        peek(8'hDD, d); check("R7 pending fault2", d, 8'h04);
        peek(8'hDC, d); check("R7 pending fault1", d, 8'h89);
        clear_faults();

        // R6 strobe at another address does not clear
        set_in(7'h09, 4'hF, 1'b1);
        @(negedge clk);
        reg_addr = 8'hDC;
        reg_rd   = 1'b1;
        edge_sample();
        reg_rd = 1'b0;
        peek(8'hDD, d); check("R6 no clear on 0xDC read", d, 8'h08);
        clear_faults();

        // R10 live status, R11 unmapped read
        @(negedge clk);
        uv_lvl = 7'h55;
        ov_lvl = 7'h2A;
        edge_sample();
        peek(8'hD8, d); check("R10 uv", d, 8'h55);
        peek(8'hD9, d); check("R10 ov", d, 8'h2A);
        peek(8'hDA, d); check("R10 det", d, 8'h09);
        peek(8'hDB, d); check("R10 gpi/wd", d, 8'h1F);
        peek(8'h00, d); check("R11 unmapped", d, 8'h00);

        // R1 reset mid-run clears a latched event and masks
        wr_reg(8'hE1, 8'h02);
        set_in(7'h00, 4'hF, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        edge_sample();
        @(negedge clk);
        rst = 1'b0;
        edge_sample();
        peek(8'hDC, d); check("R1 mid reset fault1", d, 8'h00);
        peek(8'hE1, d); check("R1 mid reset mask2", d, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule